// File: doc/BRIEF.md
# Load Value Replication Queue

This block keeps a redundant trailing thread on the same execution path as its leading twin. When the leading thread retires a load, it pushes a record into the queue: a program-order sequence number, the effective address and the returned data. The trailing thread never reads memory for its loads. It presents its own sequence number and computed address to the lookup port and takes the data from the matching record. Stores from other processors or device reads that change memory between the two threads' accesses therefore cannot make the threads diverge.

Each slot of the queue runs a small state machine with three states. SLOT_FREE is an empty slot. SLOT_LIVE holds a record that has not been read yet. SLOT_SPENT holds a record that the trailing thread has already taken but that cannot be reclaimed yet. The transitions are *alloc* (SLOT_FREE to SLOT_LIVE, on an accepted push at the tail), *consume* (SLOT_LIVE to SLOT_SPENT, on a lookup hit) and *release* (SLOT_SPENT to SLOT_FREE, when the slot sits at the head).

The trailing thread may issue its loads out of order, so a lookup searches every live slot by sequence number. Slots are reclaimed strictly in order from the head, one per cycle. A separate state machine latches address faults. It has two states, FLT_CLEAR and FLT_TRIPPED, and one transition, *trip*, taken on a hit whose stored address differs from the looked-up address. FLT_TRIPPED is left only by reset.

Top module: `load_mirror_queue`

## Requirements
- R1: After reset, `push_full`, `look_hit` and `addr_fault` are 0, and every lookup misses.
- R2: A push with `push_valid`=1 while `push_full`=0 stores the record at the clock edge. A push while `push_full`=1 is ignored, and a later lookup of its sequence number misses.
- R3: `push_full` is 1 exactly when all DEPTH slots hold records that are not yet released (SLOT_LIVE or SLOT_SPENT).
- R4: A lookup (`look_valid`=1) whose `look_seq` equals the sequence number of a live record gives `look_hit`=1 and that record's data on `look_data` in the same cycle, whatever the record's position in the queue.
- R5: A lookup that matches no live record gives `look_hit`=0 and changes no state. Retrying it after the record has been pushed hits.
- R6: A record that has been consumed never hits again.
- R7: A hit whose `look_addr` differs from the stored address still returns the stored data, and sets `addr_fault` from the next clock edge. `addr_fault` then stays 1 until reset.
- R8: An address difference on a miss, or on a cycle with `look_valid`=0, does not set `addr_fault` and consumes nothing.
- R9: Slots are released in push order. A consumed record that is not at the head keeps its slot until every older record is consumed. The head slot is released on the clock edge after it is consumed, at one slot per cycle.
- R10: A record is visible to lookups from the cycle after its push. A lookup in the same cycle as the push misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Leading thread retires a load this cycle |
| push_seq | input | SEQ_W | Program-order sequence number of the retired load |
| push_addr | input | ADDR_W | Effective address of the retired load |
| push_data | input | DATA_W | Value returned to the retired load |
| push_full | output | 1 | No free slot; the leading thread must hold load retirement |
| look_valid | input | 1 | Trailing thread requests a load value |
| look_seq | input | SEQ_W | Sequence number of the trailing load |
| look_addr | input | ADDR_W | Address computed by the trailing thread |
| look_hit | output | 1 | A live record matches; `look_data` is valid |
| look_data | output | DATA_W | Data of the matching record |
| addr_fault | output | 1 | Sticky address-mismatch indication |

## Verification
The bench builds the queue with DEPTH=4, SEQ_W=6, ADDR_W=16 and DATA_W=16. With four slots a handful of pushes fills the queue. That brings the full-stall boundary, the ignored push while full, the pointer wrap and the in-order release of a slot consumed out of order into reach in a few dozen cycles. The narrow fields keep the sequence and address patterns short while still telling apart records that differ in a single field.

// File: rtl/lmq_pkg.sv
package lmq_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_LIVE  = 2'd1,
        SLOT_SPENT = 2'd2
    } slot_state_t;

    typedef enum logic {
        FLT_CLEAR   = 1'b0,
        FLT_TRIPPED = 1'b1
    } fault_state_t;

endpackage

// File: rtl/lmq_slot.sv
module lmq_slot
    import lmq_pkg::*;
#(
    parameter int SEQ_W  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              consume_i,
    input  logic              release_i,
    input  logic [SEQ_W-1:0]  wr_seq_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              live_o,
    output logic              spent_o,
    output logic [SEQ_W-1:0]  seq_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    slot_state_t state_q, state_d;
    logic [SEQ_W-1:0]  seq_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // next-state: alloc, consume, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:  if (alloc_i)   state_d = SLOT_LIVE;
            SLOT_LIVE:  if (consume_i) state_d = SLOT_SPENT;
            SLOT_SPENT: if (release_i) state_d = SLOT_FREE;
            default:                   state_d = SLOT_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // record payload, written on alloc
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (alloc_i) begin
            seq_q  <= wr_seq_i;
            addr_q <= wr_addr_i;
            data_q <= wr_data_i;
        end
    end

    // outputs
    always_comb begin
        live_o  = (state_q == SLOT_LIVE);
        spent_o = (state_q == SLOT_SPENT);
        seq_o   = seq_q;
        addr_o  = addr_q;
        data_o  = data_q;
    end

    // R2: the tail pointer only ever allocates an empty slot
    p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> state_q == SLOT_FREE);

    // R6: only an unread record can be consumed
    p_consume_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i |-> state_q == SLOT_LIVE);

    // R9: the head is released only after it was consumed
    p_release_spent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> $past(consume_i) || state_q == SLOT_SPENT);

endmodule

// File: rtl/lmq_match.sv
module lmq_match #(
    parameter int DEPTH  = 16,
    parameter int SEQ_W  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                         look_valid_i,
    input  logic [SEQ_W-1:0]             look_seq_i,
    input  logic [DEPTH-1:0]             live_i,
    input  logic [DEPTH-1:0][SEQ_W-1:0]  seq_i,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addr_i,
    input  logic [DEPTH-1:0][DATA_W-1:0] data_i,
    output logic                         hit_o,
    output logic [PTR_W-1:0]             idx_o,
    output logic [ADDR_W-1:0]            addr_o,
    output logic [DATA_W-1:0]            data_o
);

    logic [DEPTH-1:0] eq;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = look_valid_i && live_i[g] && (seq_i[g] == look_seq_i);
    end

    // lowest-numbered matching slot wins
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit_o = 1'b1;
                idx_o = PTR_W'(i);
            end
        end
        addr_o = addr_i[idx_o];
        data_o = data_i[idx_o];
    end

endmodule

// File: rtl/lmq_fault.sv
module lmq_fault
    import lmq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch_i,
    output logic fault_o
);

    fault_state_t state_q, state_d;

    // next-state: trip
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_CLEAR:   if (mismatch_i) state_d = FLT_TRIPPED;
            FLT_TRIPPED: state_d = FLT_TRIPPED;
            default:     state_d = FLT_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_CLEAR;
        else        state_q <= state_d;
    end

    // outputs
    always_comb fault_o = (state_q == FLT_TRIPPED);

    // R7: once raised, the fault stays until reset
    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);

endmodule

// File: rtl/load_mirror_queue.sv
module load_mirror_queue
    import lmq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int SEQ_W  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_full,
    input  logic              look_valid,
    input  logic [SEQ_W-1:0]  look_seq,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data,
    output logic              addr_fault
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;

    logic [DEPTH-1:0]             live, spent;
    logic [DEPTH-1:0][SEQ_W-1:0]  slot_seq;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;

    logic              accept, release_head, mismatch;
    logic [PTR_W-1:0]  hit_idx;
    logic [ADDR_W-1:0] hit_addr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_full    = (count_q == CNT_W'(DEPTH));
    assign accept       = push_valid && !push_full;
    assign release_head = spent[head_q];
    assign mismatch     = look_hit && (look_addr != hit_addr);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        lmq_slot #(
            .SEQ_W (SEQ_W),
            .ADDR_W(ADDR_W),
            .DATA_W(DATA_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc_i  (accept && (tail_q == PTR_W'(g))),
            .consume_i(look_hit && (hit_idx == PTR_W'(g))),
            .release_i(release_head && (head_q == PTR_W'(g))),
            .wr_seq_i (push_seq),
            .wr_addr_i(push_addr),
            .wr_data_i(push_data),
            .live_o   (live[g]),
            .spent_o  (spent[g]),
            .seq_o    (slot_seq[g]),
            .addr_o   (slot_addr[g]),
            .data_o   (slot_data[g])
        );
    end

    lmq_match #(
        .DEPTH (DEPTH),
        .SEQ_W (SEQ_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_match (
        .look_valid_i(look_valid),
        .look_seq_i  (look_seq),
        .live_i      (live),
        .seq_i       (slot_seq),
        .addr_i      (slot_addr),
        .data_i      (slot_data),
        .hit_o       (look_hit),
        .idx_o       (hit_idx),
        .addr_o      (hit_addr),
        .data_o      (look_data)
    );

    lmq_fault u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .mismatch_i(mismatch),
        .fault_o   (addr_fault)
    );

    // tail advances on alloc, head on release, occupancy tracks both
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (accept)       tail_q <= bump(tail_q);
            if (release_head) head_q <= bump(head_q);
            unique case ({accept, release_head})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // R3: occupancy never exceeds the slot count
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R3: while full, occupancy cannot grow
    p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_full |=> count_q <= $past(count_q));

    // R4: a hit needs at least one record held
    p_hit_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        look_hit |-> count_q != '0);

    // R7: the fault rises only after a hit with a differing address
    p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_fault) |-> $past(look_valid && look_hit && (look_addr != hit_addr)));

endmodule

// File: tb/load_mirror_queue_bench.sv
module load_mirror_queue_bench;

    localparam int DEPTH  = 4;
    localparam int SEQ_W  = 6;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              push_valid;
    logic [SEQ_W-1:0]  push_seq;
    logic [ADDR_W-1:0] push_addr;
    logic [DATA_W-1:0] push_data;
    logic              push_full;
    logic              look_valid;
    logic [SEQ_W-1:0]  look_seq;
    logic [ADDR_W-1:0] look_addr;
    logic              look_hit;
    logic [DATA_W-1:0] look_data;
    logic              addr_fault;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    load_mirror_queue #(
        .DEPTH (DEPTH),
        .SEQ_W (SEQ_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_load_mirror_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_valid(push_valid),
        .push_seq  (push_seq),
        .push_addr (push_addr),
        .push_data (push_data),
        .push_full (push_full),
        .look_valid(look_valid),
        .look_seq  (look_seq),
        .look_addr (look_addr),
        .look_hit  (look_hit),
        .look_data (look_data),
        .addr_fault(addr_fault)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n      = 1'b0;
        push_valid = 1'b0;
        push_seq   = '0;
        push_addr  = '0;
        push_data  = '0;
        look_valid = 1'b0;
        look_seq   = '0;
        look_addr  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input int seq, input int addr, input int data);
        @(negedge clk);
        push_valid = 1'b1;
        push_seq   = SEQ_W'(seq);
        push_addr  = ADDR_W'(addr);
        push_data  = DATA_W'(data);
        @(posedge clk);
        #1 push_valid = 1'b0;
    endtask

    task automatic probe(input int seq, input int addr, input bit exp_hit,
                         input int exp_data, input string req);
        @(negedge clk);
        look_valid = 1'b1;
        look_seq   = SEQ_W'(seq);
        look_addr  = ADDR_W'(addr);
        #1;
        check(look_hit == exp_hit, req, "look_hit", 32'(look_hit), 32'(exp_hit));
        if (exp_hit)
            check(look_data == DATA_W'(exp_data), req, "look_data",
                  32'(look_data), 32'(exp_data));
        @(posedge clk);
        #1 look_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check(push_full == 1'b0, "R1", "push_full after reset", 32'(push_full), 0);
        check(addr_fault == 1'b0, "R1", "addr_fault after reset", 32'(addr_fault), 0);
        probe(0, 0, 1'b0, 0, "R1");
    endtask

    task automatic t_out_of_order();
        do_reset();
        push(10, 16'h1000, 16'hA0A0);
        push(11, 16'h1004, 16'hB1B1);
        push(12, 16'h1008, 16'hC2C2);
        probe(12, 16'h1008, 1'b1, 16'hC2C2, "R4");
        probe(10, 16'h1000, 1'b1, 16'hA0A0, "R4");
        probe(10, 16'h1000, 1'b0, 0, "R6");
        probe(11, 16'h1004, 1'b1, 16'hB1B1, "R4");
        probe(12, 16'h1008, 1'b0, 0, "R6");
        check(addr_fault == 1'b0, "R4", "no fault on matching addresses", 32'(addr_fault), 0);
    endtask

    task automatic t_miss_retry();
        do_reset();
        probe(5, 16'h2000, 1'b0, 0, "R5");
        // push and lookup of the same record in one cycle: R10
        @(negedge clk);
        push_valid = 1'b1;
        push_seq   = SEQ_W'(5);
        push_addr  = ADDR_W'(16'h2000);
        push_data  = DATA_W'(16'h5555);
        look_valid = 1'b1;
        look_seq   = SEQ_W'(5);
        look_addr  = ADDR_W'(16'h2000);
        #1;
        check(look_hit == 1'b0, "R10", "same-cycle lookup", 32'(look_hit), 0);
        @(posedge clk);
        #1;
        push_valid = 1'b0;
        look_valid = 1'b0;
        probe(5, 16'h2000, 1'b1, 16'h5555, "R5");
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            check(push_full == 1'b0, "R3", "not full before last push", 32'(push_full), 0);
            push(i, 16'h3000 + 4 * i, 16'h7000 + i);
        end
        check(push_full == 1'b1, "R3", "full after DEPTH pushes", 32'(push_full), 1);
        push(9, 16'h3100, 16'h7999);
        check(push_full == 1'b1, "R2", "full after ignored push", 32'(push_full), 1);
        probe(2, 16'h3008, 1'b1, 16'h7002, "R4");
        idle(2);
        check(push_full == 1'b1, "R9", "non-head consume keeps slot", 32'(push_full), 1);
        probe(0, 16'h3000, 1'b1, 16'h7000, "R9");
        check(push_full == 1'b1, "R9", "head not freed at consume edge", 32'(push_full), 1);
        idle(1);
        check(push_full == 1'b0, "R9", "head freed on next edge", 32'(push_full), 0);
        probe(9, 16'h3100, 1'b0, 0, "R2");
        probe(1, 16'h3004, 1'b1, 16'h7001, "R4");
        probe(3, 16'h300C, 1'b1, 16'h7003, "R4");
        idle(4);
        // wrap: refill past the end of the slot array
        for (int i = 0; i < DEPTH; i++) push(20 + i, 16'h4000 + i, 16'h8000 + i);
        check(push_full == 1'b1, "R3", "full after wrap refill", 32'(push_full), 1);
        probe(23, 16'h4003, 1'b1, 16'h8003, "R4");
        probe(20, 16'h4000, 1'b1, 16'h8000, "R4");
    endtask

    task automatic t_fault();
        do_reset();
        push(30, 16'h5000, 16'h1234);
        push(31, 16'h5004, 16'h5678);
        check(addr_fault == 1'b0, "R7", "fault clear before mismatch", 32'(addr_fault), 0);
        probe(30, 16'h5FFF, 1'b1, 16'h1234, "R7");
        check(addr_fault == 1'b1, "R7", "fault after mismatched hit", 32'(addr_fault), 1);
        probe(30, 16'h5000, 1'b0, 0, "R6");
        probe(31, 16'h5004, 1'b1, 16'h5678, "R7");
        idle(5);
        check(addr_fault == 1'b1, "R7", "fault sticky", 32'(addr_fault), 1);
    endtask

    task automatic t_ignored();
        do_reset();
        push(40, 16'h6000, 16'h4444);
        probe(41, 16'h6FFF, 1'b0, 0, "R8");
        // lookup with look_valid low and a wrong address
        @(negedge clk);
        look_valid = 1'b0;
        look_seq   = SEQ_W'(40);
        look_addr  = ADDR_W'(16'h6FFF);
        #1;
        check(look_hit == 1'b0, "R8", "hit with look_valid low", 32'(look_hit), 0);
        idle(2);
        check(addr_fault == 1'b0, "R8", "no fault from miss or idle", 32'(addr_fault), 0);
        probe(40, 16'h6000, 1'b1, 16'h4444, "R8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_out_of_order();
        t_miss_retry();
        t_full();
        t_fault();
        t_ignored();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule